// File: doc/BRIEF.md
# Pipelined Block-Copy DMA Engine

This block copies a run of words from one address range to another over a single request/response master socket. Software programs a start address for the source, a start address for the destination and a word count through a small configuration port, then sets the run bit. The engine streams read requests out as long as it has room to remember where each word must go. It turns every returned word into a write request as soon as the data arrives, so reads and writes interleave on the one port and the port stays busy.

Request and response channels are decoupled, and each has its own accept handshake, so several requests may be in flight at once. Two internal queues separate the read side from the write side. One holds the destination address of each read issued. The other holds the read data as it returns. A write is formed from the heads of both queues. The info tag of each request marks it as a read or a write, and returning responses are sorted on that tag. The engine reports completion once every write has been acknowledged.

Top module: `dma_pipe_engine`

## Requirements
- R1: After reset, all four configuration registers read 0, no request is presented (`m_req_valid` = 0) and the status shows neither busy nor done.
- R2: The configuration port maps the source start address at offset 0, the destination start address at offset 1 and the word count at offset 2. Offset 3 is the control/status word, with bit 0 = run, bit 1 = busy (run set and not yet done) and bit 2 = done. A write is visible on `cfg_rdata` from the next cycle.
- R3: A transfer of N words issues exactly N read requests, each with op 0 (read), data 0 and info tag 1, at addresses source, source+1, ... in increasing order.
- R4: Each write request carries op 1 (write) and info tag 2. The k-th write goes to destination+k and carries the data returned for read k, so the destination range ends up holding a copy of the source range.
- R5: Whenever a read response has been taken and its write has not yet been issued, the next newly presented request is that write, not a read.
- R6: The number of reads issued but not yet turned into writes never exceeds the queue depth (4). Read issue stalls at that limit and resumes as writes drain it.
- R7: Done (status bit 2) is set once the number of acknowledged writes (tag-2 responses) equals the count, and busy then clears. A count of 0 reaches done with no request issued.
- R8: While busy, writes to any configuration register, including a write that clears the run bit, are ignored.
- R9: Setting the run bit clears the internal progress counters, so a new transfer started right after a finished one copies its own full range.
- R10: With a memory that always accepts and answers 2 cycles after acceptance, an N-word transfer reaches done within 2N+10 cycles of the run write.
- R11: A request that is presented but not accepted stays presented, with unchanged op, address and data, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register offset |
| cfg_wdata | input | DW | Configuration write data |
| cfg_rdata | output | DW | Configuration read data for `cfg_addr` |
| m_req_valid | output | 1 | Request presented |
| m_req_op | output | 1 | Request op, 0 read, 1 write |
| m_req_addr | output | AW | Request address |
| m_req_data | output | DW | Write data (0 for reads) |
| m_req_info | output | 2 | Tag, 1 read, 2 write |
| m_req_accept | input | 1 | Target takes the request this cycle |
| m_resp_valid | input | 1 | Response presented |
| m_resp_op | input | 1 | Response op, 0 read, 1 write |
| m_resp_info | input | 2 | Response tag echoed from the request |
| m_resp_data | input | DW | Read data |
| m_resp_accept | output | 1 | Engine takes the response this cycle |

## Verification
Write issue and read issue compete for the single request slot. A copy against a short-latency memory makes the two collide: read data comes back while reads remain to be sent. The bench keeps its own tally of read responses taken and writes sent. At every cycle where a fresh request appears while that tally shows a pending write, it requires the request to be a write. The same collision is repeated with long latency and with a stalling target, where held requests must not switch from read to write.

// File: rtl/dma_pipe_pkg.sv
package dma_pipe_pkg;

  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;

  localparam logic [1:0] TAG_READ  = 2'd1;
  localparam logic [1:0] TAG_WRITE = 2'd2;

  localparam logic [1:0] OFS_SRC  = 2'd0;
  localparam logic [1:0] OFS_DST  = 2'd1;
  localparam logic [1:0] OFS_CNT  = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

endpackage

// File: rtl/dma_queue.sv
module dma_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] slots [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [PW:0]   fill_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (fill_q == (PW+1)'(DEPTH));
  assign empty = (fill_q == '0);
  assign head  = slots[rptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      if (push) wptr_q <= ptr_next(wptr_q);
      if (pop)  rptr_q <= ptr_next(rptr_q);
      case ({push, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wptr_q] <= din;
  end

  // R6: the queue is never written when full nor read when empty
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pipe_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          finish_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          start_o,
  output logic          active_o
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic          busy, wr_ok;
  logic          unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  assign busy     = run_q && !done_q;
  assign wr_ok    = cfg_we && !busy;
  assign start_o  = wr_ok && (cfg_addr == OFS_CTRL) && cfg_wdata[0];
  assign active_o = busy;
  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_ok) begin
      case (cfg_addr)
        OFS_SRC: src_q <= cfg_wdata[AW-1:0];
        OFS_DST: dst_q <= cfg_wdata[AW-1:0];
        OFS_CNT: cnt_q <= cfg_wdata[CW-1:0];
        default: begin
          run_q  <= cfg_wdata[0];
          done_q <= 1'b0;
        end
      endcase
    end else if (busy && finish_i) begin
      done_q <= 1'b1;
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_SRC: cfg_rdata = DW'(src_q);
      OFS_DST: cfg_rdata = DW'(dst_q);
      OFS_CNT: cfg_rdata = DW'(cnt_q);
      default: cfg_rdata = DW'({done_q, busy, run_q});
    endcase
  end

  // R8: programmed values hold while a transfer runs
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q));
  // R7: done stays until software writes the control word
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cfg_we) |=> done_q);

endmodule

// File: rtl/dma_issue.sv
module dma_issue
  import dma_pipe_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int CW     = 8,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          active_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  output logic          finish_o,
  output logic          m_req_valid,
  output logic          m_req_op,
  output logic [AW-1:0] m_req_addr,
  output logic [DW-1:0] m_req_data,
  output logic [1:0]    m_req_info,
  input  logic          m_req_accept,
  input  logic          m_resp_valid,
  input  logic          m_resp_op,
  input  logic [1:0]    m_resp_info,
  input  logic [DW-1:0] m_resp_data,
  output logic          m_resp_accept
);
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  logic [CW-1:0] rd_issued_q, wr_done_q;
  logic          held_q, held_wr_q;

  logic [AW-1:0] aq_head;
  logic [DW-1:0] dq_head;
  logic          aq_full, aq_empty, dq_full, dq_empty;

  logic want_rd, want_wr, sel_wr, fire, rd_fire, wr_fire;
  logic resp_is_rd, resp_is_wr, rd_take, wr_ack;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_step(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  // issue decisions
  assign want_rd  = active_i && (rd_issued_q < cnt_i) && !aq_full;
  assign want_wr  = !aq_empty && !dq_empty;
  assign sel_wr   = held_q ? held_wr_q : want_wr;
  assign m_req_valid = held_q || want_wr || want_rd;
  assign fire     = m_req_valid && m_req_accept;
  assign wr_fire  = fire && sel_wr;
  assign rd_fire  = fire && !sel_wr;

  assign m_req_op   = sel_wr ? OP_WRITE : OP_READ;
  assign m_req_addr = sel_wr ? aq_head : rd_addr_q;
  assign m_req_data = sel_wr ? dq_head : '0;
  assign m_req_info = sel_wr ? TAG_WRITE : TAG_READ;

  // response sorting
  assign resp_is_rd    = (m_resp_info == TAG_READ)  && (m_resp_op == OP_READ);
  assign resp_is_wr    = (m_resp_info == TAG_WRITE) && (m_resp_op == OP_WRITE);
  assign m_resp_accept = m_resp_valid && (resp_is_rd ? !dq_full : 1'b1);
  assign rd_take       = m_resp_accept && resp_is_rd;
  assign wr_ack        = m_resp_accept && resp_is_wr;

  assign finish_o = (wr_done_q == cnt_i);

  dma_queue #(.W(AW), .DEPTH(QDEPTH)) u_addr_q (
    .clk(clk), .rst_n(rst_n),
    .push(rd_fire), .din(wr_addr_q),
    .pop(wr_fire), .head(aq_head),
    .full(aq_full), .empty(aq_empty)
  );

  dma_queue #(.W(DW), .DEPTH(QDEPTH)) u_data_q (
    .clk(clk), .rst_n(rst_n),
    .push(rd_take), .din(m_resp_data),
    .pop(wr_fire), .head(dq_head),
    .full(dq_full), .empty(dq_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q   <= '0;
      wr_addr_q   <= '0;
      rd_issued_q <= '0;
      wr_done_q   <= '0;
      held_q      <= 1'b0;
      held_wr_q   <= 1'b0;
    end else if (start_i) begin
      rd_addr_q   <= src_i;
      wr_addr_q   <= dst_i;
      rd_issued_q <= '0;
      wr_done_q   <= '0;
      held_q      <= 1'b0;
      held_wr_q   <= 1'b0;
    end else begin
      if (rd_fire) begin
        rd_addr_q   <= addr_step(rd_addr_q);
        wr_addr_q   <= addr_step(wr_addr_q);
        rd_issued_q <= cnt_step(rd_issued_q);
      end
      if (wr_ack) wr_done_q <= cnt_step(wr_done_q);
      held_q    <= m_req_valid && !m_req_accept;
      held_wr_q <= sel_wr;
    end
  end

  // R11: an unaccepted request is kept unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_accept && !start_i) |=>
      m_req_valid && $stable(m_req_op) && $stable(m_req_addr) && $stable(m_req_data));
  // R5: a read is never sent fresh while a write could go
  a_r5_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !held_q) |-> (aq_empty || dq_empty));
  // R3: reads never run past the count
  a_r3_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (rd_issued_q <= cnt_i));
  // R7: acknowledged writes never exceed the count
  a_r7_ack_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (wr_done_q <= cnt_i));

endmodule

// File: rtl/dma_pipe_engine.sv
module dma_pipe_engine #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int CW     = 8,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          m_req_valid,
  output logic          m_req_op,
  output logic [AW-1:0] m_req_addr,
  output logic [DW-1:0] m_req_data,
  output logic [1:0]    m_req_info,
  input  logic          m_req_accept,
  input  logic          m_resp_valid,
  input  logic          m_resp_op,
  input  logic [1:0]    m_resp_info,
  input  logic [DW-1:0] m_resp_data,
  output logic          m_resp_accept
);
  logic [AW-1:0] src_w, dst_w;
  logic [CW-1:0] cnt_w;
  logic          start_w, active_w, finish_w;

  dma_cfg_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .finish_i(finish_w),
    .src_o(src_w), .dst_o(dst_w), .cnt_o(cnt_w),
    .start_o(start_w), .active_o(active_w)
  );

  dma_issue #(.AW(AW), .DW(DW), .CW(CW), .QDEPTH(QDEPTH)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_w), .active_i(active_w),
    .src_i(src_w), .dst_i(dst_w), .cnt_i(cnt_w),
    .finish_o(finish_w),
    .m_req_valid(m_req_valid), .m_req_op(m_req_op), .m_req_addr(m_req_addr),
    .m_req_data(m_req_data), .m_req_info(m_req_info), .m_req_accept(m_req_accept),
    .m_resp_valid(m_resp_valid), .m_resp_op(m_resp_op), .m_resp_info(m_resp_info),
    .m_resp_data(m_resp_data), .m_resp_accept(m_resp_accept)
  );

  // R1: nothing is requested while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_w && !start_w && !$past(active_w)) |-> !m_req_valid);

endmodule

// File: tb/dma_pipe_engine_tb.sv
module dma_pipe_engine_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          m_req_valid, m_req_op, m_resp_accept;
  logic [AW-1:0] m_req_addr;
  logic [DW-1:0] m_req_data;
  logic [1:0]    m_req_info;
  logic          m_req_accept = 1'b0;
  logic          m_resp_valid = 1'b0;
  logic          m_resp_op = 1'b0;
  logic [1:0]    m_resp_info = 2'd0;
  logic [DW-1:0] m_resp_data = '0;

  dma_pipe_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .m_req_valid(m_req_valid), .m_req_op(m_req_op), .m_req_addr(m_req_addr),
    .m_req_data(m_req_data), .m_req_info(m_req_info), .m_req_accept(m_req_accept),
    .m_resp_valid(m_resp_valid), .m_resp_op(m_resp_op), .m_resp_info(m_resp_info),
    .m_resp_data(m_resp_data), .m_resp_accept(m_resp_accept)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model state
  logic [DW-1:0] mem [64];
  int lat = 2, bp = 0;
  int q_ready[$];
  logic q_op[$];
  logic [1:0] q_info[$];
  logic [DW-1:0] q_data[$];

  // per-transfer tallies
  int t_src = 0, t_dst = 0;
  int rd_seen = 0, wr_seen = 0, rd_back = 0, req_seen = 0, max_out = 0;
  int rd_bad = 0, wr_bad = 0, prio_bad = 0, hold_bad = 0;
  logic pend_q = 1'b0, pend_op = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  logic [DW-1:0] pend_data = '0;

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hC0DE0000 + DW'(a) * 32'h00010003;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target memory: drives inputs at the falling edge, records the handshakes
  initial begin
    for (int a = 0; a < 64; a++) mem[a] = pat(a);
    forever begin
      @(negedge clk);
      m_req_accept = (bp == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (q_ready.size() > 0 && q_ready[0] <= cyc) begin
        m_resp_valid = 1'b1;
        m_resp_op    = q_op[0];
        m_resp_info  = q_info[0];
        m_resp_data  = q_data[0];
      end else begin
        m_resp_valid = 1'b0;
      end
      #1;
      if (m_req_valid) begin
        if (pend_q && (m_req_op != pend_op || m_req_addr != pend_addr || m_req_data != pend_data))
          hold_bad++;
        if (!pend_q && rd_back > wr_seen && m_req_op == 1'b0) prio_bad++;
      end else if (pend_q) hold_bad++;
      if (m_req_valid && m_req_accept) begin
        req_seen++;
        if (m_req_op == 1'b0) begin
          if (m_req_addr != AW'(t_src + rd_seen) || m_req_data != '0 || m_req_info != 2'd1) rd_bad++;
          rd_seen++;
          q_data.push_back(mem[m_req_addr[5:0]]);
        end else begin
          if (m_req_addr != AW'(t_dst + wr_seen) || m_req_data != pat(t_src + wr_seen) ||
              m_req_info != 2'd2) wr_bad++;
          wr_seen++;
          mem[m_req_addr[5:0]] = m_req_data;
          q_data.push_back('0);
        end
        q_ready.push_back(cyc + lat);
        q_op.push_back(m_req_op);
        q_info.push_back(m_req_info);
        if (rd_seen - wr_seen > max_out) max_out = rd_seen - wr_seen;
      end
      pend_q    = m_req_valid && !m_req_accept;
      pend_op   = m_req_op;
      pend_addr = m_req_addr;
      pend_data = m_req_data;
      if (m_resp_valid && m_resp_accept) begin
        if (q_info[0] == 2'd1) rd_back++;
        void'(q_ready.pop_front());
        void'(q_op.pop_front());
        void'(q_info.pop_front());
        void'(q_data.pop_front());
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cfg_addr = a;
    #2 d = cfg_rdata;
  endtask

  task automatic run_copy(input int src, input int dst, input int n, input int l,
                          input int b, input bit poke, input string tag);
    logic [DW-1:0] st;
    int en_cyc, done_cyc;
    bit seen_done;
    lat = l; bp = b;
    cfg_write(2'd0, DW'(src));
    cfg_write(2'd1, DW'(dst));
    cfg_write(2'd2, DW'(n));
    @(negedge clk);
    t_src = src; t_dst = dst;
    rd_seen = 0; wr_seen = 0; rd_back = 0; req_seen = 0; max_out = 0;
    rd_bad = 0; wr_bad = 0; prio_bad = 0; hold_bad = 0;
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'd1;
    en_cyc = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_addr = 2'd3;
    #2;
    if (n > 0) chk(cfg_rdata[2:0] == 3'b011, {tag, " R2 busy after run"}, cfg_rdata[2:0], 3);
    if (poke) begin
      repeat (3) @(negedge clk);
      cfg_write(2'd0, 32'h77);
      cfg_write(2'd3, 32'd0);
    end
    seen_done = 0;
    done_cyc = 0;
    for (int k = 0; k < 3000 && !seen_done; k++) begin
      cfg_read(2'd3, st);
      if (st[2]) begin seen_done = 1; done_cyc = cyc; end
    end
    chk(seen_done && st[2:0] == 3'b101, {tag, " R7 done and not busy"}, st[2:0], 5);
    chk(rd_seen == n && rd_bad == 0, {tag, " R3 read count/fields"}, rd_seen * 1000 + rd_bad, n * 1000);
    chk(wr_seen == n && wr_bad == 0, {tag, " R4 write count/fields"}, wr_seen * 1000 + wr_bad, n * 1000);
    for (int i = 0; i < n; i++)
      chk(mem[(dst + i) % 64] == pat(src + i), {tag, " R4 copied word"}, mem[(dst + i) % 64], pat(src + i));
    chk(prio_bad == 0, {tag, " R5 write before read"}, prio_bad, 0);
    chk(hold_bad == 0, {tag, " R11 held request stable"}, hold_bad, 0);
    chk(max_out <= 4, {tag, " R6 outstanding limit"}, max_out, 4);
    if (l == 2 && b == 0)
      chk(done_cyc - en_cyc <= 2 * n + 10, {tag, " R10 throughput"}, done_cyc - en_cyc, 2 * n + 10);
    if (poke) begin
      cfg_read(2'd0, st);
      chk(st == DW'(src), {tag, " R8 source kept while busy"}, st, src);
    end
  endtask

  bit wd_hit = 0;
  initial begin
    #(200000 * 20);
    wd_hit = 1;
  end

  initial begin : main
    logic [DW-1:0] v;
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
          cfg_read(2'(a), v);
          chk(v == '0, "R1 register reset value", v, 0);
        end
        chk(m_req_valid == 1'b0, "R1 no request after reset", m_req_valid, 0);
        // R2 register access
        cfg_write(2'd0, 32'd5);
        cfg_write(2'd1, 32'd40);
        cfg_write(2'd2, 32'd3);
        cfg_read(2'd0, v); chk(v == 32'd5, "R2 source readback", v, 5);
        cfg_read(2'd1, v); chk(v == 32'd40, "R2 dest readback", v, 40);
        cfg_read(2'd2, v); chk(v == 32'd3, "R2 count readback", v, 3);
        cfg_read(2'd3, v); chk(v == 32'd0, "R2 control idle", v, 0);
        // copies: pipelined, long latency with config pokes, stalling target
        run_copy(0, 32, 8, 2, 0, 0, "T1");
        run_copy(10, 44, 6, 9, 0, 1, "T2");
        chk(max_out == 4, "R6 limit reached under long latency", max_out, 4);
        run_copy(3, 52, 5, 3, 1, 0, "T3");
        // R9 back-to-back restart
        run_copy(20, 58, 4, 2, 0, 0, "T4 R9");
        // R7 zero-length copy
        run_copy(0, 0, 0, 2, 0, 0, "T5 R7 zero");
        chk(req_seen == 0, "R7 zero count issues nothing", req_seen, 0);
      end
      begin
        wait (wd_hit);
        chk(0, "watchdog expired", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule